// File: doc/BRIEF.md
# ADC Code Transition Linearity Tester

This block measures how far one output code of a 12-bit analog-to-digital converter departs from ideal. It drives a 16-bit reference DAC whose step is one sixteenth of the converter's step. It also issues convert commands to the converter and reads back each result with its done strobe. For the code under test it finds two transition edges. The lower edge is where the converter moves between the code below and the code itself. The upper edge is where it moves between the code and the code above. From the two edges it reports the code width error (DNL) and the code center error (INL), both in sixteenths of a converter LSB.

Each edge search begins half a converter LSB from the ideal center and moves the reference code one count at a time. At each test point a fixed power-of-two number of conversions is taken and the results are counted. A test point where exactly half of the results land on the high side of the edge marks the edge. Converter noise is averaged out this way. A search that would take too many steps is stopped, and the run then reports an error.

Top module: `adc_edge_linearity_tester`

## Requirements
- R1: While reset is held and after it is released, `convert`, `busy`, `done` and `meas_err` are 0, and `dac_code`, `dnl` and `inl` are 0.
- R2: A `start` pulse while idle latches `code_k` (called k here) and raises `busy`. The first conversion is taken with `dac_code` = 16·k − 8. The upper-edge search starts at 16·k + 8.
- R3: Each test point takes exactly 2^SAMPLES_LOG2 conversions (16 by default). `convert` is a one-cycle pulse, and the next pulse waits for `adc_done`. `dac_code` stays fixed within a test point.
- R4: During the lower-edge search, a result counts as high when `adc_code` ≥ k. During the upper-edge search, it counts as high when `adc_code` ≥ k+1. More than half high moves `dac_code` down by 1, fewer than half moves it up by 1, and exactly half records the edge.
- R5: The lower edge is found and recorded first. Only after that does the upper-edge search begin.
- R6: `dnl` = upper edge − lower edge − 16, as an 8-bit two's-complement value.
- R7: `inl` = floor((lower + upper)/2) − 16·k, as an 8-bit two's-complement value.
- R8: If a test point is still unbalanced after STEP_LIMIT−1 moves in one search (63 by default), the run ends with `meas_err` = 1 and `dnl` = `inl` = 0. Edges up to 63 counts from their start point are found.
- R9: `done` is high for exactly one cycle, and `busy` falls in the same cycle. `dnl`, `inl` and `meas_err` are valid from that cycle on and hold until the next `done`.
- R10: A `start` pulse while `busy` is high has no effect on the run in progress or on its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a measurement when idle |
| code_k | input | 12 | Converter code under test |
| adc_done | input | 1 | Converter result strobe |
| adc_code | input | 12 | Converter result |
| dac_code | output | 16 | Reference DAC code |
| convert | output | 1 | Convert command pulse |
| busy | output | 1 | Measurement in progress |
| done | output | 1 | Results valid pulse |
| meas_err | output | 1 | Edge search aborted |
| dnl | output | 8 | Signed width error in 1/16 LSB |
| inl | output | 8 | Signed center error in 1/16 LSB |

## Verification
The assertions assume the following about the inputs:
- `adc_done` comes only as an answer to a `convert` and lasts one cycle.
- `code_k` lies between 1 and 4094, so that 16·k ± 8 and k+1 do not wrap.
- A noisy converter sitting exactly on an edge returns each of the two neighbouring codes on half of the samples.

The bench's converter model meets all three assumptions. It answers each convert two cycles later with a single strobe. It alternates its answer when the reference code equals an edge, which gives exactly half-and-half over the even sample count. It is only given codes inside the legal range, with edges placed no more than 63 counts from their start points except in the abort cases.

// File: rtl/ltst_pkg.sv
package ltst_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_WAIT, ST_EVAL} ltst_state_e;
  typedef enum logic {EDGE_LO, EDGE_HI} ltst_edge_e;
  typedef enum logic [1:0] {V_BAL, V_HIGH, V_LOW} ltst_verdict_e;
endpackage

// File: rtl/ltst_vote.sv
module ltst_vote
  import ltst_pkg::*;
#(
  parameter int SAMPLES_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          smp_en,
  input  logic          smp_hi,
  output logic          last,
  output ltst_verdict_e verdict
);
  localparam int N  = 1 << SAMPLES_LOG2;
  localparam int CW = SAMPLES_LOG2 + 1;

  logic [CW-1:0] taken_q, taken_d, hi_q, hi_d;

  always_comb begin
    taken_d = taken_q;
    hi_d    = hi_q;
    if (clr) begin
      taken_d = '0;
      hi_d    = '0;
    end else if (smp_en) begin
      taken_d = taken_q + CW'(1);
      hi_d    = hi_q + CW'(smp_hi);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken_q <= '0;
      hi_q    <= '0;
    end else begin
      taken_q <= taken_d;
      hi_q    <= hi_d;
    end
  end

  assign last = (taken_q == CW'(N - 1));

  always_comb begin
    if (hi_q > CW'(N / 2))      verdict = V_HIGH;
    else if (hi_q < CW'(N / 2)) verdict = V_LOW;
    else                        verdict = V_BAL;
  end

  // R3: the high count never exceeds the number of samples taken
  assert_vote_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_q <= taken_q) && (taken_q <= CW'(N)));
endmodule

// File: rtl/ltst_calc.sv
module ltst_calc #(
  parameter int DUT_BITS = 12,
  parameter int REF_BITS = 16,
  parameter int RES_W    = 8
) (
  input  logic [REF_BITS-1:0] lo_edge,
  input  logic [REF_BITS-1:0] hi_edge,
  input  logic [DUT_BITS-1:0] code,
  output logic [RES_W-1:0]    dnl,
  output logic [RES_W-1:0]    inl
);
  localparam int SH   = REF_BITS - DUT_BITS;
  localparam int LSBC = 1 << SH;

  logic [REF_BITS:0]   sum;
  logic [REF_BITS-1:0] center;

  always_comb begin
    sum    = {1'b0, hi_edge} + {1'b0, lo_edge};
    center = REF_BITS'(code) << SH;
    dnl    = RES_W'(hi_edge - lo_edge - REF_BITS'(LSBC));
    inl    = RES_W'((sum >> 1) - {1'b0, center});
  end
endmodule

// File: rtl/adc_edge_linearity_tester.sv
module adc_edge_linearity_tester
  import ltst_pkg::*;
#(
  parameter int DUT_BITS     = 12,
  parameter int REF_BITS     = 16,
  parameter int SAMPLES_LOG2 = 4,
  parameter int STEP_LIMIT   = 64,
  parameter int RES_W        = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [DUT_BITS-1:0] code_k,
  input  logic                adc_done,
  input  logic [DUT_BITS-1:0] adc_code,
  output logic [REF_BITS-1:0] dac_code,
  output logic                convert,
  output logic                busy,
  output logic                done,
  output logic                meas_err,
  output logic [RES_W-1:0]    dnl,
  output logic [RES_W-1:0]    inl
);
  localparam int SH   = REF_BITS - DUT_BITS;
  localparam int HALF = 1 << (SH - 1);
  localparam int SW   = $clog2(STEP_LIMIT);

  logic [1:0] rs_q;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  ltst_state_e         state_q, state_d;
  ltst_edge_e          edge_q, edge_d;
  logic [REF_BITS-1:0] dac_q, dac_d, lo_q, lo_d, center;
  logic [DUT_BITS-1:0] k_q, k_d, thr;
  logic [SW-1:0]       steps_q, steps_d;
  logic [RES_W-1:0]    dnl_q, dnl_d, inl_q, inl_d, c_dnl, c_inl;
  logic                err_q, err_d, done_q, done_d;
  logic                vote_clr, vote_last, smp_en;
  ltst_verdict_e       verdict;

  assign center = REF_BITS'(k_q) << SH;
  assign thr    = (edge_q == EDGE_LO) ? k_q : k_q + DUT_BITS'(1);
  assign smp_en = (state_q == ST_WAIT) && adc_done;

  ltst_vote #(.SAMPLES_LOG2(SAMPLES_LOG2)) u_vote (
    .clk(clk), .rst_n(rst_s), .clr(vote_clr), .smp_en(smp_en),
    .smp_hi(adc_code >= thr), .last(vote_last), .verdict(verdict));

  ltst_calc #(.DUT_BITS(DUT_BITS), .REF_BITS(REF_BITS), .RES_W(RES_W)) u_calc (
    .lo_edge(lo_q), .hi_edge(dac_q), .code(k_q), .dnl(c_dnl), .inl(c_inl));

  always_comb begin
    state_d  = state_q;
    edge_d   = edge_q;
    dac_d    = dac_q;
    lo_d     = lo_q;
    k_d      = k_q;
    steps_d  = steps_q;
    dnl_d    = dnl_q;
    inl_d    = inl_q;
    err_d    = err_q;
    done_d   = 1'b0;
    vote_clr = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        k_d      = code_k;
        dac_d    = (REF_BITS'(code_k) << SH) - REF_BITS'(HALF);
        edge_d   = EDGE_LO;
        steps_d  = '0;
        vote_clr = 1'b1;
        state_d  = ST_CONV;
      end
      ST_CONV: state_d = ST_WAIT;
      ST_WAIT: if (adc_done) state_d = vote_last ? ST_EVAL : ST_CONV;
      default: begin
        vote_clr = 1'b1;
        state_d  = ST_CONV;
        if (verdict == V_BAL) begin
          if (edge_q == EDGE_LO) begin
            lo_d    = dac_q;
            dac_d   = center + REF_BITS'(HALF);
            edge_d  = EDGE_HI;
            steps_d = '0;
          end else begin
            dnl_d   = c_dnl;
            inl_d   = c_inl;
            err_d   = 1'b0;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end else if (steps_q == SW'(STEP_LIMIT - 1)) begin
          dnl_d   = '0;
          inl_d   = '0;
          err_d   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          steps_d = steps_q + SW'(1);
          dac_d   = (verdict == V_HIGH) ? dac_q - REF_BITS'(1) : dac_q + REF_BITS'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      edge_q  <= EDGE_LO;
      dac_q   <= '0;
      lo_q    <= '0;
      k_q     <= '0;
      steps_q <= '0;
      dnl_q   <= '0;
      inl_q   <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      dac_q   <= dac_d;
      lo_q    <= lo_d;
      k_q     <= k_d;
      steps_q <= steps_d;
      dnl_q   <= dnl_d;
      inl_q   <= inl_d;
      err_q   <= err_d;
      done_q  <= done_d;
    end
  end

  assign dac_code = dac_q;
  assign convert  = (state_q == ST_CONV);
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign meas_err = err_q;
  assign dnl      = dnl_q;
  assign inl      = inl_q;

  // R3: convert is a single-cycle pulse
  assert_conv_pulse_R3: assert property (@(posedge clk) disable iff (!rst_s)
    convert |=> !convert);
  // R4: within one edge search the reference code moves by at most one count
  assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && $past(busy) && edge_q == $past(edge_q)) |->
      (dac_q == $past(dac_q) || dac_q == $past(dac_q) + REF_BITS'(1) ||
       dac_q == $past(dac_q) - REF_BITS'(1)));
  // R8: an aborted run reports zero results
  assert_abort_zero_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (done && meas_err) |-> (dnl == '0 && inl == '0));
  // R9: done lasts one cycle and coincides with leaving busy
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (!busy && $past(busy)) ##1 !done);
  // R10: the latched code is untouched while a run is in progress
  assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (busy && $past(busy)) |-> $stable(k_q));
endmodule

// File: tb/adc_edge_linearity_tester_bench.sv
module adc_edge_linearity_tester_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] code_k = '0;
  logic        adc_done = 1'b0;
  logic [11:0] adc_code = '0;
  logic [15:0] dac_code;
  logic        convert, busy, done, meas_err;
  logic [7:0]  dnl, inl;

  int total = 0, bad = 0, issued = 0, seen = 0, cycles = 0;
  int m_k = 0, m_lo = 0, m_hi = 0, pend = 0;
  bit tog = 1'b0;

  typedef struct {int k; int err; int dnl; int inl;} exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  adc_edge_linearity_tester u_adc_edge_linearity_tester (
    .clk(clk), .rst_n(rst_n), .start(start), .code_k(code_k),
    .adc_done(adc_done), .adc_code(adc_code), .dac_code(dac_code),
    .convert(convert), .busy(busy), .done(done), .meas_err(meas_err),
    .dnl(dnl), .inl(inl));

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model: edges at m_lo and m_hi, alternating answer exactly on an edge
  function automatic int adc_model(int v);
    int c;
    if (v > m_hi)       c = m_k + 1;
    else if (v == m_hi) begin c = tog ? m_k + 1 : m_k; tog = ~tog; end
    else if (v > m_lo)  c = m_k;
    else if (v == m_lo) begin c = tog ? m_k : m_k - 1; tog = ~tog; end
    else                c = m_k - 1;
    return c;
  endfunction

  always @(negedge clk) begin
    adc_done <= 1'b0;
    if (convert) pend <= 2;
    else if (pend == 1) begin
      adc_done <= 1'b1;
      adc_code <= 12'(adc_model(int'(dac_code)));
      pend <= 0;
    end else if (pend > 1) pend <= pend - 1;
  end

  // monitor: pop expected results as the design reports them
  always @(negedge clk) begin
    if (done) begin
      exp_t e;
      if (q.size() == 0) check("R9 unexpected done", 1, 0);
      else begin
        e = q.pop_front();
        check("R8 error flag", int'(meas_err), e.err);
        check("R6 dnl", int'($signed(dnl)), e.dnl);
        check("R7 inl", int'($signed(inl)), e.inl);
      end
      seen++;
    end
  end

  task automatic run_case(int k, int lo, int hi, int err, bit poke);
    exp_t e;
    e.k = k; e.err = err;
    e.dnl = err ? 0 : hi - lo - 16;
    e.inl = err ? 0 : ((lo + hi) >> 1) - k * 16;
    q.push_back(e);
    m_k = k; m_lo = lo; m_hi = hi; tog = 1'b0;
    @(negedge clk); start = 1'b1; code_k = 12'(k);
    @(negedge clk); start = 1'b0;
    while (!convert) @(negedge clk);
    check("R2 first dac code", int'(dac_code), k * 16 - 8);
    if (poke) begin   // R10: start during busy must be ignored
      @(negedge clk); start = 1'b1; code_k = 12'(k + 1);
      @(negedge clk); start = 1'b0;
    end
    issued++;
    while (seen < issued) @(negedge clk);
    check("R9 busy low after done", int'(busy), 0);
  endtask

  initial begin
    while (cycles < 190000) begin @(posedge clk); cycles++; end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 convert in reset", int'(convert), 0);
    check("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 done after reset", int'(done), 0);
    check("R1 dac after reset", int'(dac_code), 0);
    check("R1 err after reset", int'(meas_err), 0);
    check("R1 dnl after reset", int'(dnl), 0);
    run_case(100, 1600 - 8, 1600 + 8, 0, 1'b0);        // R4 R5 ideal code
    run_case(1, 16 - 13, 16 + 15, 0, 1'b0);            // R6 R7 wide code, low boundary
    run_case(4094, 65504 - 5, 65504 + 4, 0, 1'b0);     // R7 truncated mean, top boundary
    run_case(2000, 32000 - 71, 32000 + 71, 0, 1'b0);   // R8 edges at the step reach
    run_case(300, 4800 - 72, 4800 + 8, 1, 1'b0);       // R8 abort on lower edge
    run_case(301, 4816 - 8, 4816 + 72, 1, 1'b0);       // R8 abort on upper edge
    run_case(555, 8880 - 10, 8880 + 9, 0, 1'b1);       // R10 start while busy
    run_case(2048, 32768 - 8, 32768 + 12, 0, 1'b0);    // R3 recovery after abort
    repeat (3) @(negedge clk);
    check("R9 done held low when idle", int'(done), 0);
    check("R9 queue drained", q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule